// File: doc/BRIEF.md
# Event queue writer with generation bit

This block keeps a circular queue of 32-bit entries in an on-chip array. Each accepted notification carries a 31-bit event number. It is stored in the low 31 bits of the next free slot, and the top bit holds the producer's generation bit. The producer's generation bit starts at 1 and inverts each time its write index wraps back to slot 0.

A consumer reads through the pop port. It keeps its own expected polarity, which starts at 0. A slot whose top bit equals that polarity is stale, and the pop then returns 0. A valid pop moves the read index forward, and the consumer's polarity inverts when that index wraps to 0. Because 0 means "nothing there", event number 0 is never stored. Event number 2^24 marks an inter-processor interrupt, and the pop port flags it.

The queue length is a power of two chosen by `cfg_order` and captured while reset is held. After reset the block sweeps the array to zero and accepts no notifications until the sweep is done. A notification that would overwrite an entry not yet popped is dropped, and a sticky overflow flag is raised.

Top module: `evq_ring`

## Requirements
- R1: After `rst_n` is released, `ev_ready` stays low for exactly 2^order clock cycles while the array is cleared, then rises. `overflow` and `pop_event` are 0 after reset.
- R2: `cfg_order` is sampled while `rst_n` is low and clamped to the range MIN_ORDER (8) to MAX_ORDER (10). The queue then holds 2^order entries.
- R3: Entry bit 31 is the generation bit and bits 30:0 are the event number. The producer writes generation 1 on its first lap and inverts it at every wrap of its write index to 0, so entries left over from an earlier lap are never returned.
- R4: A pop (`pop_req` high at a clock edge) returns its result on `pop_event` after that same edge, and `pop_event` is 0 on cycles with no pop. The result is the event number of the head slot, or 0 when the slot's bit 31 equals the consumer polarity. The consumer polarity starts at 0 and inverts when the read index wraps to 0.
- R5: A notification with event number 0 is accepted but stores nothing and does not set `overflow`.
- R6: When 2^order entries are unpopped, a further accepted nonzero notification is dropped and `overflow` is set to 1, where it stays until reset.
- R7: `pop_ipi` is 1 exactly when the pop result is the marker 2^24 (0x1000000).
- R8: Events come out in arrival order across several wraps of the queue.
- R9: A pop that finds no valid entry does not advance the read index, so the next stored event is returned by the next pop.
- R10: When a push and a pop happen in the same cycle on an empty queue, the pop returns 0 and the pushed event is returned by the following pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_order | input | 4 | log2 of queue length, sampled during reset |
| ev_valid | input | 1 | Notification present |
| ev_ready | output | 1 | Notifications accepted (low while clearing) |
| ev_num | input | 31 | Event number of the notification |
| pop_req | input | 1 | Consumer pop request |
| pop_event | output | 31 | Popped event number, 0 when none valid |
| pop_ipi | output | 1 | Popped event is the inter-processor marker |
| overflow | output | 1 | Sticky: a notification was dropped because the queue was full |

## Verification
A push updates the array and the fill count at the edge where `ev_valid` and `ev_ready` are both high. `overflow` therefore shows its new value one edge after the offending push, and the stored event becomes visible to a pop that starts at the next edge. A pop result is registered, so it is valid just after the edge that sampled `pop_req`. The ready rise is counted edge by edge from the release of reset. The bench drives inputs on falling edges and samples 1 ns after rising edges, so every check reads the value registered at the edge that finished the stimulus.

// File: rtl/evq_ring.sv
module evq_ring #(
  parameter int MIN_ORDER = 8,
  parameter int MAX_ORDER = 10,
  localparam int AW = MAX_ORDER,
  localparam int DEPTH = 1 << MAX_ORDER,
  localparam logic [30:0] IPI_MARK = 31'h100_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_order,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [30:0] ev_num,
  input  logic        pop_req,
  output logic [30:0] pop_event,
  output logic        pop_ipi,
  output logic        overflow
);

  function automatic logic [3:0] clamp_order(logic [3:0] o);
    if (int'(o) < MIN_ORDER) return 4'(MIN_ORDER);
    if (int'(o) > MAX_ORDER) return 4'(MAX_ORDER);
    return o;
  endfunction

  logic [3:0]    order_q;
  logic [AW:0]   cap, fill;
  logic [AW-1:0] mask, wr_idx, rd_idx, clr_idx, wr_nxt, rd_nxt;
  logic          wr_gen, rd_pol, clearing;
  logic [31:0]   mem [DEPTH];
  logic [31:0]   head;

  assign cap    = {{AW{1'b0}}, 1'b1} << order_q;
  assign mask   = AW'(cap - 1'b1);
  assign wr_nxt = (wr_idx + 1'b1) & mask;
  assign rd_nxt = (rd_idx + 1'b1) & mask;
  assign head   = mem[rd_idx];
  assign ev_ready = !clearing;

  wire accept  = ev_valid && ev_ready && (ev_num != '0);
  wire full    = (fill == cap);
  wire wr_en   = accept && !full;
  wire rd_en   = pop_req && !clearing && (head[31] != rd_pol);

  always_ff @(posedge clk) begin
    if (clearing) mem[clr_idx] <= '0;
    else if (wr_en) mem[wr_idx] <= {wr_gen, ev_num};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_q   <= clamp_order(cfg_order);
      clearing  <= 1'b1;
      clr_idx   <= '0;
      wr_idx    <= '0;
      rd_idx    <= '0;
      wr_gen    <= 1'b1;
      rd_pol    <= 1'b0;
      fill      <= '0;
      overflow  <= 1'b0;
      pop_event <= '0;
      pop_ipi   <= 1'b0;
    end else begin
      if (clearing) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == mask) clearing <= 1'b0;
      end
      if (wr_en) begin
        wr_idx <= wr_nxt;
        if (wr_nxt == '0) wr_gen <= ~wr_gen;
      end
      if (accept && full) overflow <= 1'b1;
      if (rd_en) begin
        rd_idx <= rd_nxt;
        if (rd_nxt == '0) rd_pol <= ~rd_pol;
      end
      fill      <= fill + (AW+1)'(wr_en) - (AW+1)'(rd_en);
      pop_event <= rd_en ? head[30:0] : '0;
      pop_ipi   <= rd_en && (head[30:0] == IPI_MARK);
    end
  end

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= cap);

  assert_overflow_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fill) == $past(cap));

  assert_index_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx == ((rd_idx + fill[AW-1:0]) & mask));

  assert_stale_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_event != '0) |-> $past(fill) != '0);

  assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> (fill == '0) && (pop_event == '0));

  assert_ipi_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ipi |-> pop_event == IPI_MARK);

endmodule

// File: tb/evq_ring_test.sv
module evq_ring_test;
  localparam logic [30:0] IPI = 31'h100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_order = 4'd8;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [30:0] ev_num = '0;
  logic        pop_req = 1'b0;
  logic [30:0] pop_event;
  logic        pop_ipi;
  logic        overflow;

  int n_chk = 0;
  int n_bad = 0;
  int cap = 256;
  logic [30:0] mq[$];
  logic        ovf_exp = 1'b0;

  always #2.5 clk = ~clk;

  evq_ring uut (
    .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_num(ev_num),
    .pop_req(pop_req), .pop_event(pop_event), .pop_ipi(pop_ipi),
    .overflow(overflow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [3:0] ord, int exp_len);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_order = ord;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_order = 4'd0;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (n == 1) chk("R1 ready low in clear", {31'd0, ev_ready}, 32'd0);
    end while (!ev_ready && n < 5000);
    chk("R1/R2 clear length", n, exp_len);
    chk("R1 overflow after reset", {31'd0, overflow}, 32'd0);
    chk("R1 pop_event after reset", {1'b0, pop_event}, 32'd0);
    mq.delete();
    cap = exp_len;
    ovf_exp = 1'b0;
  endtask

  task automatic push(logic [30:0] v);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_num = v;
    @(posedge clk); #1;
    ev_valid = 1'b0;
    if (v != '0) begin
      if (mq.size() < cap) mq.push_back(v);
      else ovf_exp = 1'b1;
    end
  endtask

  task automatic pop(string req);
    logic [30:0] e;
    e = (mq.size() != 0) ? mq.pop_front() : '0;
    @(negedge clk);
    pop_req = 1'b1;
    @(posedge clk); #1;
    pop_req = 1'b0;
    chk(req, {1'b0, pop_event}, {1'b0, e});
    chk({req, " R7 ipi flag"}, {31'd0, pop_ipi}, {31'd0, (e == IPI)});
  endtask

  task automatic t_basic;
    for (int i = 0; i < 5; i++) push(31'(i * 3 + 1));
    for (int i = 0; i < 5; i++) pop("R4 basic pop");
    pop("R4 empty pop returns 0");
    pop("R9 second empty pop");
    push(31'h7fff_ffff);
    pop("R9 entry after empty pops");
  endtask

  task automatic t_zero;
    push('0);
    chk("R5 no overflow on zero", {31'd0, overflow}, 32'd0);
    pop("R5 zero event not stored");
    push(31'd42);
    push('0);
    pop("R5 next real event");
    pop("R5 nothing after");
  endtask

  task automatic t_ipi;
    push(IPI);
    push(IPI + 31'd1);
    pop("R7 marker pop");
    pop("R7 non-marker pop");
  endtask

  task automatic t_wrap;
    for (int lap = 0; lap < 6; lap++) begin
      for (int i = 0; i < 100; i++) push(31'(lap * 1000 + i + 1));
      for (int i = 0; i < 100; i++) pop("R8 order across wraps");
    end
    pop("R3 stale entry after wraps");
    pop("R3 stale entry repeat");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 256; i++) push(31'(i + 7));
    @(posedge clk); #1;
    chk("R6 no overflow at full", {31'd0, overflow}, 32'd0);
    push(31'h55);
    chk("R6 overflow set", {31'd0, overflow}, {31'd0, ovf_exp});
    for (int i = 0; i < 256; i++) pop("R6 queue intact");
    pop("R6 dropped event absent");
    chk("R6 overflow sticky", {31'd0, overflow}, 32'd1);
  endtask

  task automatic t_simul;
    @(negedge clk);
    ev_valid = 1'b1;
    ev_num = 31'd99;
    pop_req = 1'b1;
    @(posedge clk); #1;
    ev_valid = 1'b0;
    pop_req = 1'b0;
    chk("R10 same-cycle pop sees empty", {1'b0, pop_event}, 32'd0);
    mq.push_back(31'd99);
    pop("R10 pushed event next pop");
  endtask

  initial begin
    do_reset(4'd8, 256);
    t_basic();
    t_zero();
    t_ipi();
    t_simul();
    t_wrap();
    do_reset(4'd3, 256);
    t_overflow();
    do_reset(4'd15, 1024);
    push(31'd5);
    pop("R2 clamped upper queue works");
    do_reset(4'd9, 512);
    for (int i = 0; i < 300; i++) push(31'(i + 1));
    for (int i = 0; i < 300; i++) pop("R2 order 9 queue");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule